// File: doc/BRIEF.md
# General-Purpose Capture/Compare/Event Timer

This block is a timer built around one 16-bit counter that wraps on its own. A two-bit mode field decides what the counter does and what the block watches. In capture mode the counter runs on every clock and a chosen edge of an external pin copies the count into a capture register. In compare mode the counter also runs on every clock, and when it equals a reference value the block flags a match and drives a compare output. In event mode the counter does not advance on clock ticks. It advances once for each chosen edge of the external pin. A fourth mode freezes the counter.

Software reaches the block through a small register port that has an address, a write strobe and write data. Reads are combinational. There are three status bits: capture, match and overflow. Each is cleared by writing 1 to it. The interrupt line is the OR of the status bits whose enable bit is set.

Top module: `gp_timer`

## Requirements
- R1: After reset the control, count, reference, capture and status registers all read 0, and `cmp_out` and `irq` are both 0.
- R2: Addresses: 0 is control, 1 is count, 2 is reference, 3 is capture (read-only), 4 is status, and any other address reads 0. Control bits [1:0] select the mode: 0 frozen, 1 capture, 2 compare, 3 event. In mode 0 the counter holds its value, and pin edges do not change it. A write to address 1 loads the counter on that edge and takes precedence over any advance on the same edge.
- R3: In modes 1 and 2 the counter advances by one on every clock. A step from FFFFh to 0000h sets status bit 2 (overflow).
- R4: The pin passes through two synchronising flops. Control bit 2 enables rising edges and bit 3 enables falling edges; both bits set enables both, and neither set enables none. An edge acts on the third rising clock edge after the pin changes, and edges of the disabled polarity are ignored.
- R5: In mode 1 an enabled edge copies the count into the capture register and sets status bit 0. The value copied is the count as it stood two clocks after the clock period in which the pin changed.
- R6: In mode 2, a clock edge at which count equals reference sets status bit 1. When control bit 4 is 0 (pulse), the output register is high for exactly the following clock period.
- R7: When control bit 4 is 1 (toggle), each match inverts the compare output, and the output holds its level between matches.
- R8: Control bit 5 enables `cmp_out`. While it is 0, `cmp_out` stays 0, yet matches still set status bit 1.
- R9: In mode 3 the counter advances by exactly one per enabled pin edge and never on clock ticks alone.
- R10: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If the bit is set and cleared on the same edge, the set wins.
- R11: `irq` is high exactly when a status bit is 1 and its enable is 1. Control bit 6 enables capture, bit 7 enables match and bit 8 enables overflow.
- R12: The capture register changes only when a capture occurs. Writes to address 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, acts on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read data for `bus_addr` |
| ext_in | input | 1 | Asynchronous external event / capture pin |
| cmp_out | output | 1 | Compare output |
| irq | output | 1 | Interrupt request |

## Verification
A wrong count value is visible at the next read of address 1. It also shifts the clock period in which `cmp_out` fires, so the bench checks the compare output in the exact period before a match, at the match and after it. A wrong edge detector or synchroniser depth shows up after three clocks, either as a capture value off by the latency or as an event count that differs from the bench's tally of enabled transitions. Status errors appear on `irq` in the same clock period as the bad bit, because the interrupt is combinational from the status and enable bits.

// File: rtl/gp_timer.sv
module gp_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    bus_addr,
  input  logic          bus_wr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          ext_in,
  output logic          cmp_out,
  output logic          irq
);

  localparam int CTW = 9;
  localparam int STW = 3;
  localparam logic [1:0] M_OFF = 2'd0;
  localparam logic [1:0] M_CAP = 2'd1;
  localparam logic [1:0] M_CMP = 2'd2;
  localparam logic [1:0] M_EVT = 2'd3;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CNT  = 3'd1;
  localparam logic [2:0] A_REF  = 3'd2;
  localparam logic [2:0] A_CAP  = 3'd3;
  localparam logic [2:0] A_ST   = 3'd4;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CTW-1:0] ctrl;
  logic [CW-1:0]  cnt, refv, cap;
  logic [STW-1:0] st, clr;
  logic [2:0]     sync;
  logic           out_q;
  logic [1:0]     mode;
  logic           edge_hit, adv, ld, wrap, hit, capev;

  assign mode     = ctrl[1:0];
  assign edge_hit = (sync[1] & ~sync[2] & ctrl[2]) | (~sync[1] & sync[2] & ctrl[3]);
  assign adv      = (mode == M_CAP) || (mode == M_CMP) || (mode == M_EVT && edge_hit);
  assign ld       = bus_wr && bus_addr == A_CNT;
  assign wrap     = adv && !ld && cnt == '1;
  assign hit      = mode == M_CMP && cnt == refv;
  assign capev    = mode == M_CAP && edge_hit;
  assign clr      = (bus_wr && bus_addr == A_ST) ? bus_wdata[STW-1:0] : '0;
  assign cmp_out  = out_q & ctrl[5];
  assign irq      = |(st & ctrl[8:6]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      refv  <= '0;
      cnt   <= '0;
      cap   <= '0;
      st    <= '0;
      sync  <= '0;
      out_q <= 1'b0;
    end else begin
      sync <= {sync[1:0], ext_in};
      if (bus_wr && bus_addr == A_CTRL) ctrl <= bus_wdata[CTW-1:0];
      if (bus_wr && bus_addr == A_REF)  refv <= bus_wdata;
      if (ld)       cnt <= bus_wdata;
      else if (adv) cnt <= cnt + ONE;
      if (capev) cap <= cnt;
      if (hit)            out_q <= ctrl[4] ? ~out_q : 1'b1;
      else if (!ctrl[4])  out_q <= 1'b0;
      st <= (st & ~clr) | {wrap, hit, capev};
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {{(CW-CTW){1'b0}}, ctrl};
      A_CNT:   bus_rdata = cnt;
      A_REF:   bus_rdata = refv;
      A_CAP:   bus_rdata = cap;
      A_ST:    bus_rdata = {{(CW-STW){1'b0}}, st};
      default: bus_rdata = '0;
    endcase
  end

  // R2
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF && !ld) |=> $stable(cnt));

  // R3
  ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && cnt == '1) |=> (cnt == '0 && st[2]));

  // R5
  cap_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capev |=> (cap == $past(cnt) && st[0]));

  // R6
  cmp_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> st[1]);

  // R9
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_EVT && !edge_hit && !ld) |=> $stable(cnt));

  // R12
  cap_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capev |=> $stable(cap));

endmodule

// File: tb/sim_gp_timer.sv
module sim_gp_timer;
  localparam int CLK_P = 10;
  localparam logic [2:0] A_CTRL = 3'd0, A_CNT = 3'd1, A_REF = 3'd2, A_CAP = 3'd3, A_ST = 3'd4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        ext_in = 1'b0;
  logic        cmp_out, irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  gp_timer u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
               .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_in(ext_in),
               .cmp_out(cmp_out), .irq(irq));

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int edge_fn(logic p, logic n, logic [1:0] es);
    return ((!p && n && es[0]) || (p && !n && es[1])) ? 1 : 0;
  endfunction

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, c0, cp, rv;
    logic o1, o2, o3, nv;
    int e, expn, k;
    logic [1:0] es;
    logic tog;
    void'($urandom(32'h5eed_0042));
    step(3);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R1 reg", v, 16'h0);
    end
    chk("R1 cmp_out", {15'h0, cmp_out}, 16'h0);
    chk("R1 irq", {15'h0, irq}, 16'h0);

    // R2 frozen mode, load, edges ignored
    wr(A_CTRL, 16'h000C);
    wr(A_CNT, 16'h1234);
    for (int i = 0; i < 6; i++) begin ext_in = ~ext_in; step(2); end
    step(4);
    rd(A_CNT, v); chk("R2 hold", v, 16'h1234);
    rd(3'd6, v); chk("R2 unmapped", v, 16'h0);

    // R3 free run and wrap
    wr(A_CTRL, 16'h0001);
    wr(A_ST, 16'h0007);
    wr(A_CNT, 16'hFFFE);
    step(1); rd(A_CNT, v); chk("R3 pre-wrap", v, 16'hFFFF);
    step(1); rd(A_CNT, v); chk("R3 wrap", v, 16'h0000);
    rd(A_ST, v); chk("R3 ovf", v, 16'h0004);
    step(5); rd(A_CNT, v); chk("R3 run", v, 16'h0005);

    // R10 write-one-to-clear
    wr(A_ST, 16'h0003); rd(A_ST, v); chk("R10 keep", v, 16'h0004);
    wr(A_ST, 16'h0004); rd(A_ST, v); chk("R10 clear", v, 16'h0000);

    // R5 directed capture with R4 latency
    wr(A_CTRL, 16'h0005);
    step(4);
    rd(A_CNT, c0);
    ext_in = 1'b1;
    step(2); rd(A_CAP, v); chk("R4 latency", v, 16'h0000);
    step(1); rd(A_CAP, v); chk("R5 capture", v, c0 + 16'd2);
    rd(A_ST, v); chk("R5 status", v, 16'h0001);
    rd(A_CAP, cp);
    ext_in = 1'b0;
    step(4); rd(A_CAP, v); chk("R4 falling ignored", v, cp);
    wr(A_CAP, 16'hABCD); rd(A_CAP, v); chk("R12 read-only", v, cp);

    // R5 random edge-select capture
    for (int i = 0; i < 6; i++) begin
      es = 2'($urandom_range(1, 3));
      wr(A_CTRL, {12'h0, es, 2'b01});
      step(4);
      nv = ~ext_in;
      e = edge_fn(ext_in, nv, es);
      rd(A_CNT, c0); rd(A_CAP, cp);
      ext_in = nv;
      step(3); rd(A_CAP, v);
      chk("R5 random capture", v, (e != 0) ? c0 + 16'd2 : cp);
    end

    // R6/R7 compare, pulse and toggle
    for (int i = 0; i < 10; i++) begin
      tog = (i < 2) ? 1'(i) : 1'($urandom_range(0, 1));
      rv  = 16'($urandom);
      k   = $urandom_range(2, 33);
      wr(A_CTRL, {10'h0, 1'b1, tog, 4'b0010});
      wr(A_REF, rv);
      wr(A_CNT, rv - 16'(k));
      wr(A_ST, 16'h0007);
      step(k - 1); o1 = cmp_out;
      rd(A_ST, v); chk("R6 no early match", v & 16'h2, 16'h0);
      step(1); o2 = cmp_out;
      rd(A_ST, v); chk("R6 match status", v & 16'h2, 16'h2);
      step(1); o3 = cmp_out;
      if (!tog) begin
        chk("R6 pulse before", {15'h0, o1}, 16'h0);
        chk("R6 pulse high", {15'h0, o2}, 16'h1);
        chk("R6 pulse end", {15'h0, o3}, 16'h0);
      end else begin
        chk("R7 toggle flip", {15'h0, o2}, {15'h0, ~o1});
        chk("R7 toggle hold", {15'h0, o3}, {15'h0, o2});
      end
    end

    // R8 output disabled
    wr(A_CTRL, 16'h0002);
    wr(A_REF, 16'h0200);
    wr(A_CNT, 16'h01FE);
    wr(A_ST, 16'h0007);
    step(2);
    chk("R8 gated", {15'h0, cmp_out}, 16'h0);
    rd(A_ST, v); chk("R8 status", v, 16'h0002);

    // R10 set wins over clear
    wr(A_CNT, 16'h0200);
    wr(A_ST, 16'h0002);
    rd(A_ST, v); chk("R10 set wins", v, 16'h0002);
    wr(A_ST, 16'h0002);
    rd(A_ST, v); chk("R10 cleared", v, 16'h0000);

    // R11 interrupt enables
    wr(A_ST, 16'h0007);
    wr(A_CNT, 16'h0200);
    step(1);
    rd(A_ST, v); chk("R11 status", v, 16'h0002);
    chk("R11 none enabled", {15'h0, irq}, 16'h0);
    wr(A_CTRL, 16'h0042); chk("R11 other enable", {15'h0, irq}, 16'h0);
    wr(A_CTRL, 16'h0082); chk("R11 match enable", {15'h0, irq}, 16'h1);
    wr(A_CTRL, 16'h0102); chk("R11 ovf enable", {15'h0, irq}, 16'h0);

    // R9 directed event counting
    ext_in = 1'b0;
    wr(A_CTRL, 16'h0007);
    step(4);
    wr(A_CNT, 16'h0000);
    step(5); rd(A_CNT, v); chk("R9 no clock advance", v, 16'h0000);
    ext_in = 1'b1;
    step(2); rd(A_CNT, v); chk("R4 event latency", v, 16'h0000);
    step(1); rd(A_CNT, v); chk("R9 one event", v, 16'h0001);

    // R9 random event streams
    for (int i = 0; i < 5; i++) begin
      es = 2'($urandom_range(1, 3));
      wr(A_CTRL, {12'h0, es, 2'b11});
      step(4);
      wr(A_CNT, 16'h0000);
      expn = 0;
      for (int j = 0; j < 40; j++) begin
        nv = 1'($urandom_range(0, 1));
        expn += edge_fn(ext_in, nv, es);
        ext_in = nv;
        step(1);
      end
      step(4);
      rd(A_CNT, v); chk("R9 random events", v, 16'(expn));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule